// File: doc/BRIEF.md
# Bus-Attached Accumulator and Adder-Subtracter Datapath

This block is the arithmetic and display section of a small computer in which every register shares one 8-bit data bus. It holds an accumulator, a second operand register, a two's-complement adder-subtracter and an 8-bit display port whose bits each drive one LED. The sequencer, memory and program counter are outside the block. They present a word on the shared bus and set a few strobes each cycle. Register loads are active-low and take effect on the rising clock edge. The two bus-drive enables are active-high.

In each cycle at most one of two internal sources may drive the shared bus: the accumulator or the adder-subtracter result. The block reports which word it drives and whether it drives at all, so the surrounding bus logic can merge it with the other sources. When neither internal source drives, the registers load the external bus word. A sum or difference is put back into the accumulator by enabling the result onto the bus and strobing the accumulator load in the same cycle. If both internal sources are enabled together, the block raises a contention flag.

Top module: `acc_alu_datapath`

## Requirements
- R1: A rising edge with `rst_n` low sets the accumulator, the operand register and `led` to 0.
- R2: The accumulator takes the current bus word on a rising edge when `ld_acc_n` is 0 and holds its value when it is 1. The bus word is the accumulator if `drv_acc` is 1, else the adder result if `drv_sum` is 1, else `bus_in`.
- R3: The operand register takes the current bus word on a rising edge when `ld_b_n` is 0 and holds its value when it is 1.
- R4: While `drv_acc` is 1, `bus_drive` is 1 and `bus_out` equals the accumulator.
- R5: While `drv_sum` is 1, `drv_acc` is 0 and `sub_sel` is 0, `bus_out` equals (accumulator + operand) mod 256, and the carry is dropped.
- R6: While `drv_sum` is 1, `drv_acc` is 0 and `sub_sel` is 1, `bus_out` equals (accumulator − operand) mod 256. This is formed as accumulator + NOT operand + 1.
- R7: `led` takes the accumulator value on a rising edge only when `drv_acc` is 1 and `ld_out_n` is 0. With `drv_acc` at 0, a low `ld_out_n` leaves `led` unchanged.
- R8: With both drive enables at 0, `bus_drive` is 0 and `bus_out` is 0, and any register load takes `bus_in`.
- R9: `contention` is 1 exactly when `drv_acc` and `drv_sum` are both 1. In that case the accumulator has priority on `bus_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low clear |
| bus_in | input | 8 | Bus word from sources outside the block |
| ld_acc_n | input | 1 | Accumulator load strobe, active low |
| drv_acc | input | 1 | Put the accumulator on the bus |
| sub_sel | input | 1 | 0 selects add, 1 selects subtract |
| drv_sum | input | 1 | Put the adder-subtracter result on the bus |
| ld_b_n | input | 1 | Operand register load strobe, active low |
| ld_out_n | input | 1 | Display port load strobe, active low |
| bus_out | output | 8 | Word this block drives onto the bus |
| bus_drive | output | 1 | This block drives the bus |
| led | output | 8 | Display port contents, one bit per LED |
| contention | output | 1 | Both internal drivers enabled at once |

## Verification
The accumulator shows up directly on `bus_out` in any cycle with `drv_acc` set, so a wrong accumulator value is visible one cycle after the faulty edge. The operand register has no direct view. A wrong operand value shows up only as a wrong sum or difference the next time `drv_sum` is set, so the random mix enables the result often, under both `sub_sel` values. A display load taken under the wrong strobes changes `led` right after that edge, and the bench checks `led` after every cycle.

// File: rtl/acc_alu_pkg.sv
// Package: acc_alu_pkg
// Shared width and bus-source type for the accumulator datapath.
// Assumes one data width for every register and the bus.
package acc_alu_pkg;
    localparam int unsigned DATA_W = 8;

    typedef enum logic [1:0] {
        SRC_EXT = 2'd0,
        SRC_ACC = 2'd1,
        SRC_SUM = 2'd2
    } bus_src_e;
endpackage

// File: rtl/dp_load_reg.sv
// Module: dp_load_reg
// A W-bit register with a synchronous active-low clear and an active-low
// load. Assumes the load strobe is already qualified by the caller.
module dp_load_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Clear on reset, take d on load, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (!ld_n)
            q <= d;
    end

    AST_REG_CLEAR: assert property (@(posedge clk) !rst_n |=> q == '0); // R1
    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n |=> $stable(q)); // R2
    AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_n |=> q == $past(d)); // R3
endmodule

// File: rtl/dp_addsub.sv
// Module: dp_addsub
// Combinational two's-complement adder-subtracter. With sub low it gives
// a + b. With sub high it gives a + ~b + 1 (the carry-in supplies the +1).
// The carry-out is dropped, so the result wraps modulo 2**W.
module dp_addsub #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum
);
    logic [W-1:0] b_eff;
    logic [W-1:0] cin;

    // Pick the operand polarity and carry-in, then add.
    always_comb begin
        b_eff = sub ? ~b : b;
        cin   = {{(W-1){1'b0}}, sub};
        sum   = a + b_eff + cin;
    end

    // Checks on the arithmetic identities.
    always_comb begin
        if (sub && (a == b))
            AST_SUB_SELF_ZERO: assert (sum == '0); // R6
        if (!sub && (b == '0))
            AST_ADD_ZERO_ID: assert (sum == a); // R5
        if (sub && (b == '0))
            AST_SUB_ZERO_ID: assert (sum == a); // R6
    end
endmodule

// File: rtl/dp_bus_select.sv
// Module: dp_bus_select
// Chooses which word this block puts on the shared bus and which word the
// registers see as the bus value. The accumulator wins over the adder when
// both are enabled, and that case raises contention. When neither drives,
// the external word is the bus value and bus_out is zero.
module dp_bus_select
    import acc_alu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         drv_acc,
    input  logic         drv_sum,
    input  logic [W-1:0] acc_q,
    input  logic [W-1:0] sum,
    input  logic [W-1:0] ext,
    output logic [W-1:0] bus_word,
    output logic [W-1:0] bus_out,
    output logic         bus_drive,
    output logic         contention
);
    bus_src_e src;

    // Decode the source by priority.
    always_comb begin
        if (drv_acc)
            src = SRC_ACC;
        else if (drv_sum)
            src = SRC_SUM;
        else
            src = SRC_EXT;
    end

    // Form the driven word, the internal bus word and the flags.
    always_comb begin
        bus_drive  = (src != SRC_EXT);
        contention = drv_acc & drv_sum;
        unique case (src)
            SRC_ACC: bus_out = acc_q;
            SRC_SUM: bus_out = sum;
            default: bus_out = '0;
        endcase
        bus_word = bus_drive ? bus_out : ext;
    end

    always_comb begin
        if (contention)
            AST_CONTENTION_ACC_WINS: assert (bus_out == acc_q); // R9
        if (!drv_acc && !drv_sum)
            AST_IDLE_PASSES_EXT: assert (bus_word == ext && bus_out == '0); // R8
    end
endmodule

// File: rtl/acc_alu_datapath.sv
// Module: acc_alu_datapath
// Top of the accumulator datapath: the accumulator, operand register and
// display port on one shared bus, plus the adder-subtracter. Assumes the
// external sequencer drives at most one source at a time. Contention is
// flagged, not prevented.
module acc_alu_datapath
    import acc_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              ld_acc_n,
    input  logic              drv_acc,
    input  logic              sub_sel,
    input  logic              drv_sum,
    input  logic              ld_b_n,
    input  logic              ld_out_n,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_drive,
    output logic [DATA_W-1:0] led,
    output logic              contention
);
    localparam int unsigned W = DATA_W;

    logic [W-1:0] acc_q;
    logic [W-1:0] opb_q;
    logic [W-1:0] sum;
    logic [W-1:0] bus_word;
    logic         led_ld_n;

    // The display port loads only while the accumulator drives the bus.
    always_comb led_ld_n = ~(drv_acc & ~ld_out_n);

    dp_load_reg #(.W(W)) u_acc (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_acc_n), .d(bus_word), .q(acc_q)
    );

    dp_load_reg #(.W(W)) u_opb (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_b_n), .d(bus_word), .q(opb_q)
    );

    dp_load_reg #(.W(W)) u_led (
        .clk(clk), .rst_n(rst_n), .ld_n(led_ld_n), .d(acc_q), .q(led)
    );

    dp_addsub #(.W(W)) u_alu (
        .a(acc_q), .b(opb_q), .sub(sub_sel), .sum(sum)
    );

    dp_bus_select #(.W(W)) u_bus (
        .drv_acc(drv_acc), .drv_sum(drv_sum), .acc_q(acc_q), .sum(sum),
        .ext(bus_in), .bus_word(bus_word), .bus_out(bus_out),
        .bus_drive(bus_drive), .contention(contention)
    );

    AST_LED_NEEDS_ACC_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_acc |=> $stable(led)); // R7
    AST_LED_TAKES_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_acc && !ld_out_n) |=> led == $past(acc_q)); // R7
    AST_ACC_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        drv_acc |-> (bus_drive && bus_out == acc_q)); // R4
    AST_ACC_FROM_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_acc_n && !drv_acc && !drv_sum) |=> acc_q == $past(bus_in)); // R8
endmodule

// File: tb/acc_alu_datapath_test.sv
module acc_alu_datapath_test;
    localparam int CLK_PER = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] bus_in;
    logic       ld_acc_n, drv_acc, sub_sel, drv_sum, ld_b_n, ld_out_n;
    logic [7:0] bus_out;
    logic       bus_drive;
    logic [7:0] led;
    logic       contention;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] m_acc, m_b, m_led;

    always #(CLK_PER/2) clk = ~clk;

    acc_alu_datapath uut (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .ld_acc_n(ld_acc_n),
        .drv_acc(drv_acc), .sub_sel(sub_sel), .drv_sum(drv_sum),
        .ld_b_n(ld_b_n), .ld_out_n(ld_out_n), .bus_out(bus_out),
        .bus_drive(bus_drive), .led(led), .contention(contention)
    );

    function automatic logic [7:0] alu_ref(input logic [7:0] a, input logic [7:0] b,
                                           input logic s);
        return s ? 8'(a - b) : 8'(a + b);
    endfunction

    function automatic logic [7:0] drive_ref(input logic da, input logic ds,
                                             input logic s);
        if (da) return m_acc;
        if (ds) return alu_ref(m_acc, m_b, s);
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check bus outputs, clock, check registers.
    task automatic cycle(input logic [7:0] bi, input logic la, input logic da,
                         input logic s, input logic ds, input logic lb, input logic lo);
        logic [7:0] word;
        @(negedge clk);
        bus_in = bi; ld_acc_n = la; drv_acc = da; sub_sel = s;
        drv_sum = ds; ld_b_n = lb; ld_out_n = lo;
        #1;
        word = (da || ds) ? drive_ref(da, ds, s) : bi;
        if (da) check("R4 bus_out", bus_out, m_acc);
        else if (ds && !s) check("R5 add", bus_out, alu_ref(m_acc, m_b, 1'b0));
        else if (ds && s) check("R6 sub", bus_out, alu_ref(m_acc, m_b, 1'b1));
        else check("R8 idle bus_out", bus_out, 8'h00);
        check("R8 bus_drive", {7'd0, bus_drive}, {7'd0, (da | ds)});
        check("R9 contention", {7'd0, contention}, {7'd0, (da & ds)});
        @(posedge clk);
        if (da && !lo) m_led = m_acc;
        if (!la) m_acc = word;
        if (!lb) m_b = word;
        #1;
        check("R7 led", led, m_led);
    endtask

    // Read the accumulator through the bus without changing anything.
    task automatic peek_acc(input string req);
        @(negedge clk);
        ld_acc_n = 1; ld_b_n = 1; ld_out_n = 1; drv_sum = 0; drv_acc = 1;
        #1;
        check(req, bus_out, m_acc);
    endtask

    initial begin
        #(CLK_PER * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd12345));
        rst_n = 0; bus_in = 8'h5A; ld_acc_n = 0; drv_acc = 0; sub_sel = 0;
        drv_sum = 0; ld_b_n = 0; ld_out_n = 0;
        repeat (2) @(posedge clk);
        #1;
        m_acc = 0; m_b = 0; m_led = 0;
        check("R1 led clear", led, 8'h00);
        @(negedge clk);
        rst_n = 1; ld_acc_n = 1; ld_b_n = 1; ld_out_n = 1;
        peek_acc("R1 acc clear");
        // Operand clear: sum with zero acc must be zero.
        cycle(8'h00, 1, 0, 0, 1, 1, 1);

        // Directed: load acc, load b, add with wrap.
        cycle(8'hF0, 0, 0, 0, 0, 1, 1);           // R2 acc <- ext
        cycle(8'h20, 1, 0, 0, 0, 0, 1);           // R3 b <- ext
        cycle(8'h00, 0, 0, 0, 1, 1, 1);           // R5 acc <- F0+20 = 10
        peek_acc("R5 wrap add into acc");
        check("R5 wrap value", m_acc, 8'h10);
        // Subtract below zero: 10 - 20 = F0.
        cycle(8'h00, 0, 0, 1, 1, 1, 1);
        peek_acc("R6 borrow wrap");
        check("R6 wrap value", m_acc, 8'hF0);
        // Hold: loads high, ext changes.
        cycle(8'h33, 1, 0, 0, 0, 1, 1);
        peek_acc("R2 hold");
        // Display: strobe without acc drive must not load.
        cycle(8'h44, 1, 0, 0, 0, 1, 0);
        check("R7 no load without drive", led, 8'h00);
        cycle(8'h44, 1, 1, 0, 0, 1, 0);
        check("R7 load with drive", led, 8'hF0);
        // B loads from acc drive; then A - A = 0.
        cycle(8'h00, 1, 1, 0, 0, 0, 1);
        cycle(8'h00, 1, 0, 1, 1, 1, 1);
        // Contention corner: flag set, acc wins.
        cycle(8'h77, 1, 1, 0, 1, 1, 1);
        cycle(8'h00, 1, 0, 0, 0, 1, 1);

        // Random mix, no contention.
        for (int i = 0; i < 3000; i++) begin
            int sel;
            logic da, ds;
            sel = int'($urandom_range(0, 2));
            da = (sel == 1);
            ds = (sel == 2);
            cycle(8'($urandom), 1'($urandom), da, 1'($urandom), ds,
                  1'($urandom), 1'($urandom));
        end

        // Reset mid-run clears everything again.
        @(negedge clk);
        rst_n = 0;
        @(posedge clk);
        #1;
        m_acc = 0; m_b = 0; m_led = 0;
        check("R1 led reclear", led, 8'h00);
        @(negedge clk);
        rst_n = 1;
        peek_acc("R1 acc reclear");
        cycle(8'h00, 1, 0, 0, 1, 1, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule